// File: doc/BRIEF.md
# Dual-Channel Host Bus Slave

This block lets an external master processor trade bytes with a local controller over a parallel 8-bit bus. The block is the slave on that bus. It has two channels. Each channel holds a byte that the host writes, a byte that the local side loads for the host to read, and a status byte that the host can poll. The local side gets flag outputs and two merged interrupt request lines. The first line tells it that fresh host data has arrived. The second tells it that the host has taken the byte it left.

The host strobes come from another clock domain. Each one passes through a short synchronizer chain and acts once, when it is released. The data, A0 and select values present while the strobe was held are captured and then committed. The host can use a single read/write level qualified by a strobe, or separate read and write strobes. Channel 1 answers only when dual-channel mode is on. A master enable parks the whole interface.

Top module: `hbus_slave`

## Requirements
- R1: After a synchronous reset, all IBF and OBF flags and both interrupt request outputs are 0.
- R2: A host write to a channel stores the bus byte in that channel's input buffer, sets its IBF flag and latches the host A0 value. It acts once per strobe, at the strobe's release.
- R3: The channel status byte, from bit 7 down to bit 0, is {user bits 4..1, latched A0, user bit 0, IBF, OBF}. The local side writes the 5 user bits through `l_user_wdata` (bit 4 down to bit 0).
- R4: A host read with A0=0 returns the output buffer and then clears OBF. A host read with A0=1 returns the status byte and leaves OBF unchanged.
- R5: A local load of a channel's output buffer sets that channel's OBF.
- R6: A local read of the input buffer (`l_ibuf_re`, channel `l_ch`) returns the stored byte and clears that channel's IBF.
- R7: With `cfg_rw_style`=1 an access is `h_stb_n`=0 with `h_rnw` (1 read, 0 write). With `cfg_rw_style`=0 an access is `h_rd_n`=0 or `h_wr_n`=0.
- R8: Selects are active low (`h_cs_n[0]` channel 0, `h_cs_n[1]` channel 1). With `cfg_dual`=0, `h_cs_n[1]` is ignored: no flag changes and no bus drive. With `cfg_dual`=1, channel 1 works like channel 0.
- R9: Each 0-to-1 change of either IBF flag raises `irq_ibf` for PULSE_W cycles. The pulse starts two clock cycles after the flag rises.
- R10: Each OBF clear caused by a host read raises `irq_obe` for PULSE_W cycles. A local load gives no pulse.
- R11: `h_data` is driven only while the interface is enabled, a valid channel is selected and a host read is active. Otherwise it is high impedance.
- R12: With `cfg_en`=0, all IBF and OBF flags and the latched A0 values are cleared and held clear, and host accesses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Interface master enable |
| cfg_dual | input | 1 | 1 enables channel 1 |
| cfg_rw_style | input | 1 | 1: R/W level plus strobe; 0: separate RD/WR |
| h_cs_n | input | 2 | Host channel selects, active low |
| h_a0 | input | 1 | Host address line |
| h_rnw | input | 1 | Host read/not-write level (strobe style) |
| h_stb_n | input | 1 | Host strobe, active low (strobe style) |
| h_rd_n | input | 1 | Host read strobe, active low |
| h_wr_n | input | 1 | Host write strobe, active low |
| h_data | inout | 8 | Host tri-state data bus |
| l_ch | input | 1 | Local channel index |
| l_obuf_we | input | 1 | Load output buffer of channel `l_ch` |
| l_obuf_wdata | input | 8 | Output buffer load value |
| l_user_we | input | 1 | Write user bits of channel `l_ch` |
| l_user_wdata | input | 5 | User bits {U7,U6,U5,U4,U2} |
| l_ibuf_re | input | 1 | Read-acknowledge of channel `l_ch` input buffer |
| l_ibuf_rdata | output | 8 | Input buffer of channel `l_ch` |
| l_ibf | output | 2 | IBF flags per channel |
| l_obf | output | 2 | OBF flags per channel |
| irq_ibf | output | 1 | Merged input-buffer-full request |
| irq_obe | output | 1 | Merged output-buffer-empty request |

## Verification
The bench holds each host strobe for several cycles and then counts interrupt pulses. A design that acted on the strobe level, rather than on its release, would show extra IBF pulses or would clear OBF too early. Status-port reads must leave OBF set, so a design that ignored A0 on the clear path would fire `irq_obe` when it should not. Single-mode accesses to channel 1 and accesses while the interface is disabled are made while the bench drives a known pattern on the bus. Any drive from the design corrupts that pattern, and any wrong flag update shows on the flag outputs. The single-pulse width is also measured, which catches a design that does not stretch the pulse or stretches it by the wrong amount.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
  localparam int DW   = 8;
  localparam int NCH  = 2;
  localparam int UW   = 5;

  typedef struct packed {
    logic [3:0] uhi;
    logic       a0;
    logic       ulo;
    logic       ibf;
    logic       obf;
  } hstat_t;
endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic done
);
  logic [STAGES-1:0] sh;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '0;
      prev <= 1'b0;
    end else begin
      sh   <= {sh[STAGES-2:0], din};
      prev <= sh[STAGES-1];
    end
  end

  assign done = prev & ~sh[STAGES-1];
endmodule

// File: rtl/hbus_pulse.sv
module hbus_pulse #(
  parameter int PULSE_W = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  output logic pulse
);
  localparam int CW = $clog2(PULSE_W + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (trig)        cnt <= CW'(PULSE_W);
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign pulse = (cnt != '0);
endmodule

// File: rtl/hbus_chan.sv
module hbus_chan
  import hbus_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic          cap_a0,
  input  logic [DW-1:0] cap_d,
  input  logic          obuf_we,
  input  logic [DW-1:0] obuf_d,
  input  logic          user_we,
  input  logic [UW-1:0] user_d,
  input  logic          ibuf_re,
  output logic [DW-1:0] ibuf,
  output logic [DW-1:0] obuf,
  output hstat_t        stat,
  output logic          ibf_rise,
  output logic          obe_fall
);
  logic          ibf, obf, ibf_d, obf_d, a0_lat;
  logic [UW-1:0] user;

  always_ff @(posedge clk) begin
    if (rst) begin
      ibuf   <= '0;
      obuf   <= '0;
      user   <= '0;
      a0_lat <= 1'b0;
      ibf    <= 1'b0;
      obf    <= 1'b0;
      ibf_d  <= 1'b0;
      obf_d  <= 1'b0;
    end else begin
      ibf_d <= ibf;
      obf_d <= obf;
      if (obuf_we) obuf <= obuf_d;
      if (user_we) user <= user_d;
      if (!en) begin
        ibf    <= 1'b0;
        obf    <= 1'b0;
        a0_lat <= 1'b0;
      end else begin
        if (host_wr) begin
          ibuf   <= cap_d;
          a0_lat <= cap_a0;
          ibf    <= 1'b1;
        end else if (ibuf_re) begin
          ibf <= 1'b0;
        end
        if (obuf_we)      obf <= 1'b1;
        else if (host_rd) obf <= 1'b0;
      end
    end
  end

  assign stat     = '{uhi: user[4:1], a0: a0_lat, ulo: user[0], ibf: ibf, obf: obf};
  assign ibf_rise = ibf & ~ibf_d;
  assign obe_fall = obf_d & ~obf & en;
endmodule

// File: rtl/hbus_slave.sv
module hbus_slave
  import hbus_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PULSE_W     = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_en,
  input  logic          cfg_dual,
  input  logic          cfg_rw_style,
  input  logic [1:0]    h_cs_n,
  input  logic          h_a0,
  input  logic          h_rnw,
  input  logic          h_stb_n,
  input  logic          h_rd_n,
  input  logic          h_wr_n,
  inout  wire  [7:0]    h_data,
  input  logic          l_ch,
  input  logic          l_obuf_we,
  input  logic [7:0]    l_obuf_wdata,
  input  logic          l_user_we,
  input  logic [4:0]    l_user_wdata,
  input  logic          l_ibuf_re,
  output logic [7:0]    l_ibuf_rdata,
  output logic [1:0]    l_ibf,
  output logic [1:0]    l_obf,
  output logic          irq_ibf,
  output logic          irq_obe
);
  logic           wr_raw, rd_raw, acc_wr, acc_rd, wr_done, rd_done;
  logic [NCH-1:0] sel_raw, cap_sel, ibf_trig, obe_trig, ibf_p, obe_p;
  logic           cap_a0;
  logic [DW-1:0]  cap_d, bus_dout;
  logic [DW-1:0]  ibuf_v [NCH];
  logic [DW-1:0]  obuf_v [NCH];
  hstat_t         stat_v [NCH];

  // Strobe decode for the two host styles
  assign wr_raw = cfg_rw_style ? (~h_stb_n & ~h_rnw) : ~h_wr_n;
  assign rd_raw = cfg_rw_style ? (~h_stb_n &  h_rnw) : ~h_rd_n;
  assign sel_raw[0] = ~h_cs_n[0];
  assign sel_raw[1] = ~h_cs_n[1] & cfg_dual;
  assign acc_wr = cfg_en & wr_raw & (|sel_raw);
  assign acc_rd = cfg_en & rd_raw & (|sel_raw);

  // Hold the access context while the strobe is held
  always_ff @(posedge clk) begin
    if (rst) begin
      cap_sel <= '0;
      cap_a0  <= 1'b0;
      cap_d   <= '0;
    end else if (acc_wr | acc_rd) begin
      cap_sel <= sel_raw;
      cap_a0  <= h_a0;
      cap_d   <= h_data;
    end
  end

  hbus_sync #(.STAGES(SYNC_STAGES)) u_sync_wr (.clk(clk), .rst(rst), .din(acc_wr), .done(wr_done));
  hbus_sync #(.STAGES(SYNC_STAGES)) u_sync_rd (.clk(clk), .rst(rst), .din(acc_rd), .done(rd_done));

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic here;
    assign here = (l_ch == 1'(g));

    hbus_chan u_ch (
      .clk      (clk),
      .rst      (rst),
      .en       (cfg_en),
      .host_wr  (wr_done & cap_sel[g] & cfg_en),
      .host_rd  (rd_done & cap_sel[g] & ~cap_a0 & cfg_en),
      .cap_a0   (cap_a0),
      .cap_d    (cap_d),
      .obuf_we  (l_obuf_we & here),
      .obuf_d   (l_obuf_wdata),
      .user_we  (l_user_we & here),
      .user_d   (l_user_wdata),
      .ibuf_re  (l_ibuf_re & here),
      .ibuf     (ibuf_v[g]),
      .obuf     (obuf_v[g]),
      .stat     (stat_v[g]),
      .ibf_rise (ibf_trig[g]),
      .obe_fall (obe_trig[g])
    );

    hbus_pulse #(.PULSE_W(PULSE_W)) u_pi (.clk(clk), .rst(rst), .trig(ibf_trig[g]), .pulse(ibf_p[g]));
    hbus_pulse #(.PULSE_W(PULSE_W)) u_po (.clk(clk), .rst(rst), .trig(obe_trig[g]), .pulse(obe_p[g]));

    assign l_ibf[g] = stat_v[g].ibf;
    assign l_obf[g] = stat_v[g].obf;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_ibf <= 1'b0;
      irq_obe <= 1'b0;
    end else begin
      irq_ibf <= |ibf_p;
      irq_obe <= |obe_p;
    end
  end

  // Host read path: channel 0 wins if both are selected
  always_comb begin
    if (sel_raw[0]) bus_dout = h_a0 ? stat_v[0] : obuf_v[0];
    else            bus_dout = h_a0 ? stat_v[1] : obuf_v[1];
  end

  assign h_data       = acc_rd ? bus_dout : {DW{1'bz}};
  assign l_ibuf_rdata = ibuf_v[l_ch];
endmodule

// File: rtl/hbus_slave_chk.sv
module hbus_slave_chk (
  input logic       clk,
  input logic       rst,
  input logic       cfg_en,
  input logic       l_ch,
  input logic       l_obuf_we,
  input logic       l_ibuf_re,
  input logic [1:0] l_ibf,
  input logic [1:0] l_obf,
  input logic       irq_ibf,
  input logic       irq_obe
);
  // R12: disabled interface holds every flag clear
  p_flags_off_r12: assert property (@(posedge clk) disable iff (rst)
    !cfg_en |=> (l_ibf == 2'b00 && l_obf == 2'b00));

  // R5: local load sets OBF of the addressed channel
  p_obf_set_r5: assert property (@(posedge clk) disable iff (rst)
    (cfg_en && l_obuf_we && l_ch == 1'b0) |=> l_obf[0]);

  // R6: IBF stays set until a local read or disable
  p_ibf_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (cfg_en && l_ibf[1] && !(l_ibuf_re && l_ch == 1'b1)) |=> (l_ibf[1] || !cfg_en));

  // R9: IBF rise raises the merged request two cycles later
  p_ibf_irq_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(l_ibf[0]) |=> ##1 irq_ibf);

  // R10: an OBE request only follows a set OBF
  p_obe_src_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_obe) |-> $past(|l_obf, 3));
endmodule

bind hbus_slave hbus_slave_chk u_chk (.*);

// File: tb/hbus_slave_bench.sv
module hbus_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_en = 1'b1, cfg_dual = 1'b1, cfg_rw_style = 1'b0;
  logic [1:0] h_cs_n = 2'b11;
  logic h_a0 = 1'b0, h_rnw = 1'b1, h_stb_n = 1'b1, h_rd_n = 1'b1, h_wr_n = 1'b1;
  logic tb_oe = 1'b0;
  logic [7:0] tb_d = 8'h00;
  wire  [7:0] hd;
  logic l_ch = 1'b0, l_obuf_we = 1'b0, l_user_we = 1'b0, l_ibuf_re = 1'b0;
  logic [7:0] l_obuf_wdata = 8'h00;
  logic [4:0] l_user_wdata = 5'h00;
  logic [7:0] l_ibuf_rdata;
  logic [1:0] l_ibf, l_obf;
  logic irq_ibf, irq_obe;

  assign hd = tb_oe ? tb_d : 8'bz;
  always #(CLK_PERIOD/2) clk = ~clk;

  hbus_slave #(.SYNC_STAGES(2), .PULSE_W(PW)) u_hbus_slave (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_dual(cfg_dual), .cfg_rw_style(cfg_rw_style),
    .h_cs_n(h_cs_n), .h_a0(h_a0), .h_rnw(h_rnw), .h_stb_n(h_stb_n), .h_rd_n(h_rd_n),
    .h_wr_n(h_wr_n), .h_data(hd), .l_ch(l_ch), .l_obuf_we(l_obuf_we),
    .l_obuf_wdata(l_obuf_wdata), .l_user_we(l_user_we), .l_user_wdata(l_user_wdata),
    .l_ibuf_re(l_ibuf_re), .l_ibuf_rdata(l_ibuf_rdata), .l_ibf(l_ibf), .l_obf(l_obf),
    .irq_ibf(irq_ibf), .irq_obe(irq_obe));

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  // reference model
  logic [7:0] m_ibuf [2];
  logic [7:0] m_obuf [2];
  logic [4:0] m_user [2];
  logic       m_a0 [2];
  logic [1:0] m_ibf = 2'b00, m_obf = 2'b00;
  int exp_ip = 0, exp_op = 0, got_ip = 0, got_op = 0, ip_hi = 0;
  logic pi = 1'b0, po = 1'b0;

  always @(posedge clk) begin
    if (!rst) begin
      if (irq_ibf && !pi) got_ip++;
      if (irq_obe && !po) got_op++;
      if (irq_ibf) ip_hi++;
    end
    pi <= irq_ibf;
    po <= irq_obe;
  end

  function automatic logic [7:0] m_stat(input int c);
    return {m_user[c][4:1], m_a0[c], m_user[c][0], m_ibf[c], m_obf[c]};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_flags(input string req);
    check(l_ibf == m_ibf, req, l_ibf, m_ibf);
    check(l_obf == m_obf, req, l_obf, m_obf);
  endtask

  // host access: wr=1 write d; bg=1 drives background pattern during a read
  task automatic host_acc(input int ch, input bit a0, input bit wr, input logic [7:0] d,
                          input bit bg, output logic [7:0] q);
    @(negedge clk);
    h_cs_n = (ch == 0) ? 2'b10 : 2'b01;
    h_a0 = a0;
    if (wr || bg) begin tb_oe = 1'b1; tb_d = wr ? d : 8'hA5; end
    if (cfg_rw_style) begin h_rnw = !wr; h_stb_n = 1'b0; end
    else if (wr) h_wr_n = 1'b0;
    else h_rd_n = 1'b0;
    repeat (2) @(negedge clk);
    q = hd;
    @(negedge clk);
    h_stb_n = 1'b1; h_rd_n = 1'b1; h_wr_n = 1'b1;
    @(negedge clk);
    h_cs_n = 2'b11; tb_oe = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  task automatic do_hwrite(input int ch, input bit a0, input logic [7:0] d);
    logic [7:0] q;
    bit valid = cfg_en && (ch == 0 || cfg_dual);
    host_acc(ch, a0, 1'b1, d, 1'b0, q);
    if (valid) begin
      if (!m_ibf[ch]) exp_ip++;
      m_ibuf[ch] = d; m_a0[ch] = a0; m_ibf[ch] = 1'b1;
    end
    check_flags("R2 host write flags");
  endtask

  task automatic do_hread(input int ch, input bit a0);
    logic [7:0] q, e;
    bit valid = cfg_en && (ch == 0 || cfg_dual);
    e = valid ? (a0 ? m_stat(ch) : m_obuf[ch]) : 8'hA5;
    host_acc(ch, a0, 1'b0, 8'h00, !valid, q);
    if (valid) check(q == e, a0 ? "R3 status read" : "R4 obuf read", q, e);
    else       check(q == e, "R11 bus hi-z when not addressed", q, e);
    if (valid && !a0) begin
      if (m_obf[ch]) exp_op++;
      m_obf[ch] = 1'b0;
    end
    check_flags("R4 host read flags");
  endtask

  task automatic do_load(input int ch, input logic [7:0] d);
    @(negedge clk);
    l_ch = ch[0]; l_obuf_we = 1'b1; l_obuf_wdata = d;
    @(negedge clk);
    l_obuf_we = 1'b0;
    m_obuf[ch] = d;
    if (cfg_en) m_obf[ch] = 1'b1;
    check_flags("R5 local load sets OBF");
    repeat (8) @(negedge clk);
  endtask

  task automatic do_lread(input int ch);
    @(negedge clk);
    l_ch = ch[0];
    #1;
    check(l_ibuf_rdata == m_ibuf[ch], "R6 local ibuf data", l_ibuf_rdata, m_ibuf[ch]);
    l_ibuf_re = 1'b1;
    @(negedge clk);
    l_ibuf_re = 1'b0;
    m_ibf[ch] = 1'b0;
    check_flags("R6 local read clears IBF");
  endtask

  task automatic do_user(input int ch, input logic [4:0] u);
    @(negedge clk);
    l_ch = ch[0]; l_user_we = 1'b1; l_user_wdata = u;
    @(negedge clk);
    l_user_we = 1'b0;
    m_user[ch] = u;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int c = 0; c < 2; c++) begin
      m_ibuf[c] = 8'h00; m_obuf[c] = 8'h00; m_user[c] = 5'h00; m_a0[c] = 1'b0;
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_flags("R1 reset flags");
    check({irq_ibf, irq_obe} == 2'b00, "R1 reset irqs", {irq_ibf, irq_obe}, 0);

    // R9: single pulse width and status layout (R3)
    ip_hi = 0;
    do_hwrite(0, 1'b1, 8'h5A);
    check(ip_hi == PW, "R9 irq_ibf pulse width", ip_hi, PW);
    do_user(0, 5'b10110);
    do_hread(0, 1'b1);
    // R2: second write to a full channel gives no new pulse
    do_hwrite(0, 1'b0, 8'hC3);
    do_lread(0);
    // R4/R10: status read keeps OBF, data read clears it
    do_load(1, 8'h3C);
    do_hread(1, 1'b1);
    do_hread(1, 1'b0);
    check(got_op == exp_op, "R10 irq_obe pulse count", got_op, exp_op);

    // R8: single mode ignores channel 1
    cfg_dual = 1'b0;
    do_load(1, 8'h77);
    do_hwrite(1, 1'b1, 8'h11);
    do_hread(1, 1'b0);
    cfg_dual = 1'b1;
    do_hread(1, 1'b0);

    // R12: disable clears and blocks
    do_hwrite(1, 1'b1, 8'h99);
    @(negedge clk);
    cfg_en = 1'b0;
    m_ibf = 2'b00; m_obf = 2'b00; m_a0[0] = 1'b0; m_a0[1] = 1'b0;
    @(negedge clk);
    check_flags("R12 disable clears flags");
    do_hwrite(0, 1'b0, 8'h42);
    do_hread(0, 1'b1);
    cfg_en = 1'b1;
    @(negedge clk);

    // R7: random traffic under both strobe styles
    for (int ph = 0; ph < 2; ph++) begin
      cfg_rw_style = ph[0];
      for (int i = 0; i < 60; i++) begin
        int op = int'($urandom % 5);
        int ch = int'($urandom % 2);
        case (op)
          0: do_hwrite(ch, 1'($urandom), 8'($urandom));
          1: do_hread(ch, 1'($urandom));
          2: do_load(ch, 8'($urandom));
          3: do_lread(ch);
          default: do_user(ch, 5'($urandom));
        endcase
      end
      check(got_ip == exp_ip, "R7 R9 irq_ibf pulse count", got_ip, exp_ip);
      check(got_op == exp_op, "R7 R10 irq_obe pulse count", got_op, exp_op);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule